// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator with Reload Pulse

This block drives three half-bridges from a single triangular time base. An up/down counter rises from zero to a programmable peak and falls back, so one switching period lasts twice the peak value in clock cycles. Each bridge leg has a high-side and a low-side output. Each leg has two compare thresholds, one used while the counter rises and one used while it falls, so the pulse can be placed symmetrically or shifted within the period. A programmable guard interval keeps both switches of a leg off at every change of state.

The six compare thresholds are written to staging registers. They reach the comparators only at a reload, and only when software has armed the transfer with a load-enable bit. A reload can happen at the valley of the counter, at its peak, or at both. A divider takes every Nth of these opportunities, with N from one to four. Every reload emits a one-cycle pulse. This pulse does not depend on the load-enable bit, so a downstream timer or converter trigger can be aligned to the middle of the low-side conduction window. With the default parameters and a 200 MHz clock, a peak of 12500 gives a 125 µs period.

Top module: `cpwm_gen`

## Requirements
- R1: The counter visits 0,1,…,M while counting up and M-1,…,1 while counting down, so one period is 2·M cycles. M is written at address 12, and values below 2 are stored as 2. When both thresholds of a leg equal v, the high-side output of that leg is high for 0 cycles per period if v=0, 2v-1 cycles if 1≤v≤M, and 2M cycles if v>M.
- R2: Leg p compares the counter against threshold 2p while counting up (including the valley and peak samples) and against threshold 2p+1 while counting down. With thresholds a and b, the high-side output is high for min(a,M+1)+clamp(b-1,0,M-1) cycles per period.
- R3: With a guard interval of 0, the low-side output of each leg is the complement of its high-side output.
- R4: With a guard interval D>0 (address 13), both outputs of a leg are low for D cycles after each change of the comparator result, which gives 2D both-low cycles per period. The two outputs of a leg are never high together.
- R5: A valley opportunity occurs when the counter is 0 and a peak opportunity occurs when it reaches M. Configuration bit 2 (address 14) enables valley opportunities and bit 3 enables peak opportunities. Both are enabled after reset, and a change to them takes effect at once.
- R6: Configuration bits [1:0] hold N-1. A reload is taken on every Nth enabled opportunity, so the reload spacing is N·M cycles with both opportunity kinds enabled and 2N·M cycles with one kind enabled.
- R7: A new N takes effect at the first reload after it is written. The divider restarts from that reload.
- R8: The reload pulse is high for exactly one cycle per reload, and it is produced whether or not the load-enable bit is set.
- R9: Thresholds are written at addresses 0 to 5. They are copied to the comparators at a reload only if the load-enable bit (address 15, bit 0) is 1, and the copy clears that bit. A write of the bit in the same cycle as a reload wins over the clear.
- R10: While reset is asserted, all six outputs and the reload pulse are low. Reset values are: thresholds 0, M equal to the default parameter, guard interval 0, N=1, both opportunity kinds enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | CNT_W | Register write data |
| pwmTop | output | NUM_PAIRS | High-side switch drive, one bit per leg |
| pwmBot | output | NUM_PAIRS | Low-side switch drive, one bit per leg |
| reloadSync | output | 1 | One-cycle pulse after each reload |

## Verification
On every cycle, the assertions check the following: the two switches of a leg are never on together, a guard interval forces both outputs low after a comparator change, the reload pulse is one cycle wide and follows each reload, the divider count stays within N, the comparators hold their thresholds unless an armed reload occurs, and an armed reload clears the load-enable bit. The duty formulas for symmetric and shifted thresholds, the reload spacing for every combination of divider and opportunity kind, and the deferred take-over of a new divider can only be shown by the bench's sweeps. The same holds for the survival of staged values across unarmed reloads.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_MOD  = 4'd12;
  localparam logic [ADDR_W-1:0] ADDR_DT   = 4'd13;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 4'd14;
  localparam logic [ADDR_W-1:0] ADDR_LOAD = 4'd15;

  typedef struct packed {
    logic reload;
    logic countUp;
  } ctrlStrobe_t;
endpackage

// File: rtl/cpwm_ctrl.sv
module cpwm_ctrl
  import cpwm_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int DT_W    = 6,
  parameter int DEF_MOD = 12500,
  parameter int MAX_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cnt,
  output logic [DT_W-1:0]   deadTime,
  output ctrlStrobe_t       strobe,
  output logic              syncOut
);
  localparam int FREQ_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
  localparam int FULL_BIT = FREQ_W;
  localparam int HALF_BIT = FREQ_W + 1;
  localparam logic [FREQ_W-1:0] MAX_CODE = FREQ_W'(MAX_DIV - 1);
  localparam logic [CNT_W-1:0]  MIN_MOD  = CNT_W'(2);

  logic [CNT_W-1:0]  modReg;
  logic [FREQ_W-1:0] freqPend;
  logic [FREQ_W-1:0] freqAct;
  logic [FREQ_W-1:0] oppCnt;
  logic              fullEn;
  logic              halfEn;
  logic              dirUp;
  logic              fullOpp;
  logic              halfOpp;
  logic              oppTaken;
  logic              reloadNow;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modReg   <= CNT_W'(DEF_MOD);
      deadTime <= '0;
      freqPend <= '0;
      fullEn   <= 1'b1;
      halfEn   <= 1'b1;
    end else if (wrEn) begin
      if (wrAddr == ADDR_MOD) begin
        modReg <= (wrData < MIN_MOD) ? MIN_MOD : wrData;
      end
      if (wrAddr == ADDR_DT) begin
        deadTime <= wrData[DT_W-1:0];
      end
      if (wrAddr == ADDR_CFG) begin
        freqPend <= (wrData[FREQ_W-1:0] > MAX_CODE) ? MAX_CODE : wrData[FREQ_W-1:0];
        fullEn   <= wrData[FULL_BIT];
        halfEn   <= wrData[HALF_BIT];
      end
    end
  end

  // triangular time base
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      dirUp <= 1'b1;
    end else if (dirUp) begin
      if (cnt >= modReg) begin
        cnt   <= cnt - 1'b1;
        dirUp <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        dirUp <= 1'b1;
      end
    end
  end

  // reload opportunity selection and divider
  always_comb begin
    fullOpp   = (cnt == '0);
    halfOpp   = dirUp && (cnt >= modReg);
    oppTaken  = (fullOpp && fullEn) || (halfOpp && halfEn);
    reloadNow = oppTaken && (oppCnt == freqAct);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oppCnt  <= '0;
      freqAct <= '0;
      syncOut <= 1'b0;
    end else begin
      syncOut <= reloadNow;
      if (reloadNow) begin
        oppCnt  <= '0;
        freqAct <= freqPend;
      end else if (oppTaken) begin
        oppCnt <= oppCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.reload  = reloadNow;
    strobe.countUp = dirUp;
  end

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |=> !syncOut); // R8
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    oppCnt <= freqAct); // R6
  AST_PEAK_TURNS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && cnt != '0) |=> !dirUp); // R5
endmodule

// File: rtl/cpwm_dpath.sv
module cpwm_dpath
  import cpwm_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int NUM_PAIRS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [CNT_W-1:0]     wrData,
  input  ctrlStrobe_t          strobe,
  input  logic [CNT_W-1:0]     cnt,
  output logic [NUM_PAIRS-1:0] rawTop
);
  localparam int NUM_OUT = 2 * NUM_PAIRS;

  logic [CNT_W-1:0] bufVal [NUM_OUT];
  logic [CNT_W-1:0] actVal [NUM_OUT];
  logic             loadOk;
  logic             loadWr;

  always_comb loadWr = wrEn && (wrAddr == ADDR_LOAD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_OUT; i++) begin
        bufVal[i] <= '0;
        actVal[i] <= '0;
      end
      loadOk <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (wrEn && (wrAddr == ADDR_W'(i))) begin
          bufVal[i] <= wrData;
        end
      end
      if (strobe.reload && loadOk) begin
        for (int i = 0; i < NUM_OUT; i++) begin
          actVal[i] <= bufVal[i];
        end
        loadOk <= 1'b0;
      end
      if (loadWr) begin
        loadOk <= wrData[0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_cmp
    always_comb begin
      rawTop[p] = strobe.countUp ? (cnt < actVal[2*p]) : (cnt < actVal[2*p+1]);
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_hold
    AST_HOLD_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.reload && loadOk) |=> $stable(actVal[i])); // R9
  end

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && loadOk && !loadWr) |=> !loadOk); // R9
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DT_W-1:0] deadTime,
  input  logic            rawIn,
  output logic            outTop,
  output logic            outBot
);
  logic            stateQ;
  logic [DT_W-1:0] timerQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= 1'b0;
      timerQ <= '0;
      outTop <= 1'b0;
      outBot <= 1'b0;
    end else if (rawIn != stateQ) begin
      stateQ <= rawIn;
      if (deadTime == '0) begin
        timerQ <= '0;
        outTop <= rawIn;
        outBot <= !rawIn;
      end else begin
        timerQ <= deadTime;
        outTop <= 1'b0;
        outBot <= 1'b0;
      end
    end else if (timerQ != '0) begin
      timerQ <= timerQ - 1'b1;
      if (timerQ == DT_W'(1)) begin
        outTop <= stateQ;
        outBot <= !stateQ;
      end
    end else begin
      outTop <= stateQ;
      outBot <= !stateQ;
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !(outTop && outBot)); // R4
  AST_GUARD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (deadTime != '0 && rawIn != stateQ) |=> (!outTop && !outBot)); // R4
endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen
  import cpwm_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int CNT_W     = 14,
  parameter int DT_W      = 6,
  parameter int DEF_MOD   = 12500,
  parameter int MAX_DIV   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [3:0]           wrAddr,
  input  logic [CNT_W-1:0]     wrData,
  output logic [NUM_PAIRS-1:0] pwmTop,
  output logic [NUM_PAIRS-1:0] pwmBot,
  output logic                 reloadSync
);
  ctrlStrobe_t          strobe;
  logic [CNT_W-1:0]     cnt;
  logic [DT_W-1:0]      deadTime;
  logic [NUM_PAIRS-1:0] rawTop;

  cpwm_ctrl #(
    .CNT_W(CNT_W), .DT_W(DT_W), .DEF_MOD(DEF_MOD), .MAX_DIV(MAX_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cnt(cnt), .deadTime(deadTime), .strobe(strobe), .syncOut(reloadSync)
  );

  cpwm_dpath #(
    .CNT_W(CNT_W), .NUM_PAIRS(NUM_PAIRS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .cnt(cnt), .rawTop(rawTop)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_leg
    cpwm_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rstN(rstN), .deadTime(deadTime), .rawIn(rawTop[p]),
      .outTop(pwmTop[p]), .outBot(pwmBot[p])
    );
  end

  AST_SYNC_FOLLOWS_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> reloadSync); // R8
endmodule

// File: tb/cpwm_gen_test.sv
`timescale 1ns/1ps
module cpwm_gen_test;
  localparam int NP  = 3;
  localparam int CW  = 14;
  localparam int MOD = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [3:0]    wrAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic [NP-1:0] pwmTop;
  logic [NP-1:0] pwmBot;
  logic          reloadSync;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  cpwm_gen uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmTop(pwmTop), .pwmBot(pwmBot), .reloadSync(reloadSync)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = CW'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitSync(input int n);
    for (int k = 0; k < n; k++) begin
      int g = 0;
      do begin @(negedge clk); g++; end while (!reloadSync && g < 2000);
    end
  endtask

  task automatic interval(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!reloadSync && n < 2000);
  endtask

  task automatic measure(input int p, output int t, output int b, output int lo);
    t = 0; b = 0; lo = 0;
    for (int k = 0; k < 2*MOD; k++) begin
      @(negedge clk);
      t += int'(pwmTop[p]); b += int'(pwmBot[p]);
      if (!pwmTop[p] && !pwmBot[p]) lo++;
    end
  endtask

  function automatic int symHigh(input int v);
    if (v == 0) return 0;
    if (v <= MOD) return 2*v - 1;
    return 2*MOD;
  endfunction

  task automatic loadAll(input int up [NP], input int dn [NP]);
    for (int p = 0; p < NP; p++) begin
      wr(2*p, up[p]); wr(2*p+1, dn[p]);
    end
    wr(15, 1);
    waitSync(3);
  endtask

  initial begin
    int t, b, lo, n, n2;
    int up [NP];
    int dn [NP];
    repeat (3) @(negedge clk);
    chk(pwmTop == '0 && pwmBot == '0, "R10 outputs in reset", int'({pwmTop, pwmBot}), 0);
    chk(reloadSync == 1'b0, "R10 sync in reset", int'(reloadSync), 0);
    rstN = 1'b1;
    @(negedge clk);
    wr(12, MOD);
    waitSync(2);

    // R1/R3: symmetric sweep of thresholds, guard interval 0
    for (int v = 0; v <= MOD + 1; v++) begin
      for (int p = 0; p < NP; p++) begin
        up[p] = (v + p) % (MOD + 2); dn[p] = up[p];
      end
      loadAll(up, dn);
      for (int p = 0; p < NP; p++) begin
        measure(p, t, b, lo);
        chk(t == symHigh(up[p]), "R1 high-side count", t, symHigh(up[p]));
        chk(b == 2*MOD - t && lo == 0, "R3 complement", b, 2*MOD - symHigh(up[p]));
      end
    end

    // R2: shifted thresholds
    up = '{2, 0, 7}; dn = '{5, 3, 1};
    loadAll(up, dn);
    for (int p = 0; p < NP; p++) begin
      int e;
      e = ((up[p] < MOD + 1) ? up[p] : MOD + 1) +
          ((dn[p] - 1 < 0) ? 0 : ((dn[p] - 1 > MOD - 1) ? MOD - 1 : dn[p] - 1));
      measure(p, t, b, lo);
      chk(t == e, "R2 shifted high-side count", t, e);
    end

    // R4: guard interval of 2
    wr(13, 2);
    up = '{3, 4, 3}; dn = '{3, 4, 3};
    loadAll(up, dn);
    for (int p = 0; p < 2; p++) begin
      int L;
      L = 2*up[p] - 1;
      measure(p, t, b, lo);
      chk(t == L - 2, "R4 high-side with guard", t, L - 2);
      chk(b == 2*MOD - L - 2, "R4 low-side with guard", b, 2*MOD - L - 2);
      chk(lo == 4, "R4 both-low cycles", lo, 4);
    end
    wr(13, 0);

    // R9/R8: staged values without arming
    up = '{3, 3, 3}; dn = '{3, 3, 3};
    loadAll(up, dn);
    for (int p = 0; p < NP; p++) begin wr(2*p, 5); wr(2*p+1, 5); end
    n = 0;
    for (int k = 0; k < 6*MOD; k++) begin @(negedge clk); n += int'(reloadSync); end
    chk(n == 6, "R8 pulses while unarmed", n, 6);
    measure(0, t, b, lo);
    chk(t == 5, "R9 unarmed reload keeps thresholds", t, 5);
    wr(15, 1);
    waitSync(3);
    measure(0, t, b, lo);
    chk(t == 9, "R9 armed reload applies thresholds", t, 9);
    for (int p = 0; p < NP; p++) begin wr(2*p, 2); wr(2*p+1, 2); end
    waitSync(4);
    measure(0, t, b, lo);
    chk(t == 9, "R9 arm bit cleared after transfer", t, 9);

    // R5/R6: divider x opportunity kinds
    for (int kind = 0; kind < 3; kind++) begin
      for (int N = 1; N <= 4; N++) begin
        int en, e;
        en = (kind == 0) ? 12 : ((kind == 1) ? 4 : 8);
        e  = (kind == 0) ? N*MOD : 2*N*MOD;
        wr(14, en | (N - 1));
        waitSync(3);
        interval(n);
        chk(n == e, (kind == 0) ? "R6 spacing both kinds" : "R5 spacing one kind", n, e);
        @(negedge clk);
        chk(reloadSync == 1'b0, "R8 pulse width", int'(reloadSync), 0);
        waitSync(1);
      end
    end

    // R7: deferred divider change
    wr(14, 12);
    waitSync(3);
    wrEn = 1'b1; wrAddr = 4'd14; wrData = CW'(12 | 3);
    n = 0;
    do begin @(negedge clk); wrEn = 1'b0; n++; end while (!reloadSync && n < 2000);
    interval(n2);
    chk(n == MOD, "R7 old divider until next reload", n, MOD);
    chk(n2 == 4*MOD, "R7 new divider after reload", n2, 4*MOD);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule